// File: doc/BRIEF.md
# Self-Timed Conversion Sequencer with Level Alerts

This block starts converter cycles without host help. An internal timer counts a 1 MHz tick and, at the end of every programmed period, requests a conversion. With the timer disabled, conversions follow rising edges of an external convert input instead. Each request takes the next channel from a programmable channel list, pulses a one-cycle convert strobe and drives the channel number to the converter core. The pointer returns to list entry 0 after the last programmed entry.

When the converter core hands back its 16-bit result, the block compares it with the high and low limits of the channel just converted. A crossing sets a sticky per-channel, per-direction flag. A hysteresis band stops the same alert from firing again until the level has moved back clear of the limit. The interrupt output is the OR of all flags whose mask bit is set, so a host can sleep until a level event occurs and then clear the flags by writing ones to them.

Top module: `acs_sequencer`

## Requirements
- R1: After reset conv_start and irq are 0 and the registers at addresses 0x00 (control), 0x03 (high flags) and 0x04 (low flags) read 0.
- R2: With control bit 0 (auto) set, conv_start pulses for one cycle after the N-th tick_1us pulse counted from enabling, and again every N ticks after that. N is 10, 20, 40, 80, 160, 320, 640 or 800 for period code 0..7 in control bits 3:1.
- R3: With auto clear, each rising edge of ext_cnv gives a conv_start pulse in the next cycle and tick_1us has no effect. With auto set, ext_cnv has no effect.
- R4: Each conv_start presents on conv_ch the channel held in list entry p (address 0x10+p, bits 3:0; entry p resets to p). p starts at 0, steps by one per conversion and wraps to 0 after the entry given by control bits 7:4.
- R5: From conv_start until res_valid, further start requests are dropped and do not advance the list pointer.
- R6: A result strictly above the high limit of the converted channel (0x20+ch) sets high flag bit ch (address 0x03) while that channel's high detector is armed, and disarms it. The detector rearms only on a result strictly below the high limit minus the hysteresis (0x40+ch), floored at 0.
- R7: A result strictly below the low limit (0x30+ch) sets low flag bit ch (address 0x04) while armed and disarms it. The detector rearms only on a result strictly above the low limit plus the hysteresis, capped at 0xFFFF.
- R8: Writing a one to a flag bit at 0x03 or 0x04 clears that bit. Zero bits are left unchanged.
- R9: irq is high exactly when some high flag has its bit set in the high mask (0x01) or some low flag has its bit set in the low mask (0x02).
- R10: res_valid while no conversion is outstanding has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| ext_cnv | input | 1 | External convert request, rising-edge active |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| conv_start | output | 1 | One-cycle convert strobe to the converter core |
| conv_ch | output | 4 | Channel to convert |
| res_valid | input | 1 | Result strobe from the converter core |
| res_data | input | 16 | Conversion result |
| irq | output | 1 | Level-alert interrupt |

## Verification
A pointer that advances wrongly shows up on conv_ch at the very next conversion, so the table walk compares the channel on every strobe. A detector armed in the wrong state does not show until the next result for that channel. For this reason the bench clears flags and then sends results inside the hysteresis band, where a wrongly rearmed detector would set a flag again. A stuck busy state or a mis-scaled timer shows as a missing or late strobe, measured in ticks from enabling.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int PCODE_W    = 3;
  localparam int BASE_TICKS = 10;
  localparam int MAX_TICKS  = 800;

  typedef logic [SAMPLE_W-1:0] sample_t;

  // register groups, selected by address bits 6:4
  localparam logic [2:0] GRP_CTRL = 3'd0;
  localparam logic [2:0] GRP_LIST = 3'd1;
  localparam logic [2:0] GRP_HI   = 3'd2;
  localparam logic [2:0] GRP_LO   = 3'd3;
  localparam logic [2:0] GRP_HYST = 3'd4;

  localparam logic [3:0] OFS_CTRL    = 4'd0;
  localparam logic [3:0] OFS_HI_MASK = 4'd1;
  localparam logic [3:0] OFS_LO_MASK = 4'd2;
  localparam logic [3:0] OFS_HI_FLAG = 4'd3;
  localparam logic [3:0] OFS_LO_FLAG = 4'd4;

  // period in ticks: doubling from the base, last code is capped
  function automatic int unsigned period_ticks(input logic [PCODE_W-1:0] code);
    if (code == '1) return MAX_TICKS;
    return BASE_TICKS << code;
  endfunction

  // high detector rearm level: limit minus hysteresis, floored at zero
  function automatic sample_t hi_rearm(input sample_t lim, input sample_t hy);
    return (lim > hy) ? sample_t'(lim - hy) : '0;
  endfunction

  // low detector rearm level: limit plus hysteresis, capped at full scale
  function automatic sample_t lo_rearm(input sample_t lim, input sample_t hy);
    logic [SAMPLE_W:0] sum;
    sum = {1'b0, lim} + {1'b0, hy};
    return sum[SAMPLE_W] ? '1 : sum[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/acs_timer.sv
module acs_timer
  import acs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_en,
  input  logic [PCODE_W-1:0] period_code,
  input  logic               tick,
  input  logic               ext_cnv,
  output logic               start_req
);
  localparam int CNT_W = $clog2(MAX_TICKS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic             ext_q;
  logic             period_done;
  logic             ext_rise;

  assign last_cnt    = CNT_W'(period_ticks(period_code) - 1);
  assign period_done = tick && (cnt >= last_cnt);
  assign ext_rise    = ext_cnv && !ext_q;
  assign start_req   = auto_en ? period_done : ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext_cnv;
      if (!auto_en)         cnt <= '0;
      else if (period_done) cnt <= '0;
      else if (tick)        cnt <= cnt + 1'b1;
    end
  end

  // R3: with auto off the tick counter stays idle
  p_cnt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> cnt == '0);

  // R2: the counter never runs past the programmed period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && $stable(period_code) && $past(auto_en) |-> cnt <= last_cnt);
endmodule

// File: rtl/acs_list.sv
module acs_list
  import acs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CH_W  = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ent_we,
  input  logic [IDX_W-1:0] ent_idx,
  input  logic [CH_W-1:0]  ent_ch,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             start_req,
  input  logic             res_valid,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  output logic             res_accept
);
  logic [CH_W-1:0]  entry [DEPTH];
  logic [IDX_W-1:0] ptr;
  logic             busy;
  logic             fire;
  logic             at_last;

  assign fire       = start_req && !busy;
  assign res_accept = res_valid && busy;
  assign at_last    = (ptr >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) entry[i] <= CH_W'(i);
    end else if (ent_we) begin
      entry[ent_idx] <= ent_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= '0;
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_ch    <= '0;
    end else begin
      conv_start <= fire;
      if (fire) begin
        conv_ch <= entry[ptr];
        ptr     <= at_last ? '0 : ptr + 1'b1;
        busy    <= 1'b1;
      end else if (res_accept) begin
        busy <= 1'b0;
      end
    end
  end

  // R2: the convert strobe is a single-cycle pulse
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R4: the pointer wraps after the last programmed entry
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && at_last |=> ptr == '0);

  // R5: while a result is outstanding nothing advances the pointer
  p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !res_valid |=> busy && $stable(ptr) && !conv_start);
endmodule

// File: rtl/acs_alert.sv
module acs_alert
  import acs_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic              hy_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  sample_t           cfg_data,
  input  logic [NUM_CH-1:0] hi_clr,
  input  logic [NUM_CH-1:0] lo_clr,
  input  logic              res_accept,
  input  logic [CH_W-1:0]   res_ch,
  input  sample_t           res_data,
  output logic [NUM_CH-1:0] hi_flags,
  output logic [NUM_CH-1:0] lo_flags
);
  sample_t           hi_lim [NUM_CH];
  sample_t           lo_lim [NUM_CH];
  sample_t           hy_val [NUM_CH];
  logic [NUM_CH-1:0] hi_armed;
  logic [NUM_CH-1:0] lo_armed;

  sample_t           sel_hi, sel_lo, sel_hy;
  logic [NUM_CH-1:0] ch_onehot;
  logic              hi_trip, lo_trip, hi_back, lo_back;
  logic [NUM_CH-1:0] hi_set, lo_set;

  assign sel_hi    = hi_lim[res_ch];
  assign sel_lo    = lo_lim[res_ch];
  assign sel_hy    = hy_val[res_ch];
  assign ch_onehot = NUM_CH'(1) << res_ch;

  assign hi_trip = res_accept &&  hi_armed[res_ch] && (res_data > sel_hi);
  assign lo_trip = res_accept &&  lo_armed[res_ch] && (res_data < sel_lo);
  assign hi_back = res_accept && !hi_armed[res_ch] && (res_data < hi_rearm(sel_hi, sel_hy));
  assign lo_back = res_accept && !lo_armed[res_ch] && (res_data > lo_rearm(sel_lo, sel_hy));
  assign hi_set  = hi_trip ? ch_onehot : '0;
  assign lo_set  = lo_trip ? ch_onehot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        hi_lim[c] <= '1;
        lo_lim[c] <= '0;
        hy_val[c] <= '0;
      end
    end else begin
      if (hi_we) hi_lim[cfg_ch] <= cfg_data;
      if (lo_we) lo_lim[cfg_ch] <= cfg_data;
      if (hy_we) hy_val[cfg_ch] <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_armed <= '1;
      lo_armed <= '1;
      hi_flags <= '0;
      lo_flags <= '0;
    end else begin
      hi_flags <= (hi_flags & ~hi_clr) | hi_set;
      lo_flags <= (lo_flags & ~lo_clr) | lo_set;
      if (hi_trip)      hi_armed[res_ch] <= 1'b0;
      else if (hi_back) hi_armed[res_ch] <= 1'b1;
      if (lo_trip)      lo_armed[res_ch] <= 1'b0;
      else if (lo_back) lo_armed[res_ch] <= 1'b1;
    end
  end

  // R6: an armed channel above its high limit ends with its flag set
  p_hi_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept && hi_armed[res_ch] && (res_data > sel_hi)
      |=> (hi_flags & $past(ch_onehot)) != '0);

  // R7: an armed channel below its low limit ends with its flag set
  p_lo_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept && lo_armed[res_ch] && (res_data < sel_lo)
      |=> (lo_flags & $past(ch_onehot)) != '0);

  // R8: cleared bits are gone unless a new event sets them again
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_clr != '0) && !res_accept |=> (hi_flags & $past(hi_clr)) == '0);

  // R10: with no accepted result the flags only ever lose bits
  p_no_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_accept |=> (hi_flags & ~$past(hi_flags)) == '0 && (lo_flags & ~$past(lo_flags)) == '0);
endmodule

// File: rtl/acs_sequencer.sv
module acs_sequencer
  import acs_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int LIST_DEPTH = 16,
  parameter int ADDR_W     = 7,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int IDX_W = $clog2(LIST_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_1us,
  input  logic                ext_cnv,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic                conv_start,
  output logic [CH_W-1:0]     conv_ch,
  input  logic                res_valid,
  input  logic [SAMPLE_W-1:0] res_data,
  output logic                irq
);
  logic               auto_en;
  logic [PCODE_W-1:0] period_code;
  logic [IDX_W-1:0]   last_idx;
  logic [NUM_CH-1:0]  hi_mask, lo_mask;
  logic [NUM_CH-1:0]  hi_flags, lo_flags;
  logic [NUM_CH-1:0]  hi_clr, lo_clr;
  logic               start_req;
  logic               res_accept;

  logic [2:0] w_grp;
  logic [3:0] w_ofs;
  logic       ctrl_hit;

  assign w_grp    = wr_addr[ADDR_W-1:4];
  assign w_ofs    = wr_addr[3:0];
  assign ctrl_hit = wr_en && (w_grp == GRP_CTRL);
  assign hi_clr   = (ctrl_hit && w_ofs == OFS_HI_FLAG) ? wr_data[NUM_CH-1:0] : '0;
  assign lo_clr   = (ctrl_hit && w_ofs == OFS_LO_FLAG) ? wr_data[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_en     <= 1'b0;
      period_code <= '0;
      last_idx    <= '0;
      hi_mask     <= '0;
      lo_mask     <= '0;
    end else if (ctrl_hit) begin
      case (w_ofs)
        OFS_CTRL: begin
          auto_en     <= wr_data[0];
          period_code <= wr_data[PCODE_W:1];
          last_idx    <= wr_data[4 +: IDX_W];
        end
        OFS_HI_MASK: hi_mask <= wr_data[NUM_CH-1:0];
        OFS_LO_MASK: lo_mask <= wr_data[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  acs_timer u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_en     (auto_en),
    .period_code (period_code),
    .tick        (tick_1us),
    .ext_cnv     (ext_cnv),
    .start_req   (start_req)
  );

  acs_list #(.DEPTH(LIST_DEPTH), .CH_W(CH_W)) u_list (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_we     (wr_en && (w_grp == GRP_LIST)),
    .ent_idx    (wr_addr[IDX_W-1:0]),
    .ent_ch     (wr_data[CH_W-1:0]),
    .last_idx   (last_idx),
    .start_req  (start_req),
    .res_valid  (res_valid),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .res_accept (res_accept)
  );

  acs_alert #(.NUM_CH(NUM_CH)) u_alert (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_we      (wr_en && (w_grp == GRP_HI)),
    .lo_we      (wr_en && (w_grp == GRP_LO)),
    .hy_we      (wr_en && (w_grp == GRP_HYST)),
    .cfg_ch     (wr_addr[CH_W-1:0]),
    .cfg_data   (wr_data),
    .hi_clr     (hi_clr),
    .lo_clr     (lo_clr),
    .res_accept (res_accept),
    .res_ch     (conv_ch),
    .res_data   (res_data),
    .hi_flags   (hi_flags),
    .lo_flags   (lo_flags)
  );

  assign irq = |((hi_flags & hi_mask) | (lo_flags & lo_mask));

  always_comb begin
    rd_data = '0;
    if (rd_addr[ADDR_W-1:4] == GRP_CTRL) begin
      case (rd_addr[3:0])
        OFS_CTRL:    rd_data = SAMPLE_W'({last_idx, period_code, auto_en});
        OFS_HI_MASK: rd_data = SAMPLE_W'(hi_mask);
        OFS_LO_MASK: rd_data = SAMPLE_W'(lo_mask);
        OFS_HI_FLAG: rd_data = SAMPLE_W'(hi_flags);
        OFS_LO_FLAG: rd_data = SAMPLE_W'(lo_flags);
        default:     rd_data = '0;
      endcase
    end
  end

  // R9: the interrupt can only rise after a result or a mask write
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(res_accept) || $past(ctrl_hit));

  // R1: no convert strobe in the first cycle out of reset
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !conv_start);
endmodule

// File: tb/acs_sequencer_bench.sv
module acs_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1us = 1'b0, ext_cnv = 1'b0, wr_en = 1'b0, res_valid = 1'b0;
  logic [6:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, res_data = '0, rd_data;
  logic        conv_start, irq;
  logic [3:0]  conv_ch;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acs_sequencer u_acs_sequencer (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .ext_cnv(ext_cnv),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .conv_start(conv_start), .conv_ch(conv_ch),
    .res_valid(res_valid), .res_data(res_data), .irq(irq)
  );

  // {channel expected, result, high flags after, low flags after}
  localparam int NV = 12;
  localparam logic [51:0] VEC [NV] = '{
    {4'd5, 16'd1000, 16'h0000, 16'h0000},
    {4'd2, 16'd501,  16'h0004, 16'h0000},
    {4'd9, 16'd999,  16'h0004, 16'h0200},
    {4'd5, 16'd1001, 16'h0024, 16'h0200},
    {4'd5, 16'd500,  16'h0024, 16'h0200},
    {4'd2, 16'd100,  16'h0024, 16'h0200},
    {4'd9, 16'd1050, 16'h0024, 16'h0200},
    {4'd5, 16'd199,  16'h0024, 16'h0220},
    {4'd5, 16'd1500, 16'h0024, 16'h0220},
    {4'd2, 16'd99,   16'h0024, 16'h0224},
    {4'd9, 16'd1101, 16'h0024, 16'h0224},
    {4'd5, 16'd600,  16'h0024, 16'h0224}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output int v);
    @(negedge clk); rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic pulse_ext(output logic st, output logic [3:0] ch);
    @(negedge clk); ext_cnv = 1'b1;
    @(negedge clk); ext_cnv = 1'b0; st = conv_start; ch = conv_ch;
  endtask

  task automatic pulse_tick(output logic st);
    @(negedge clk); tick_1us = 1'b1;
    @(negedge clk); tick_1us = 1'b0; st = conv_start;
  endtask

  task automatic give(input logic [15:0] v);
    @(negedge clk); res_valid = 1'b1; res_data = v;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic conv(input string req, input int exp_ch, input logic [15:0] v);
    logic st; logic [3:0] ch;
    pulse_ext(st, ch);
    check(req, "strobe", int'(st), 1);
    check("R4", "channel", int'(ch), exp_ch);
    give(v);
  endtask

  task automatic ticks_to_start(output int n);
    logic st;
    n = -1;
    for (int i = 1; i <= 1000; i++) begin
      pulse_tick(st);
      if (st) begin n = i; break; end
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v, n;
    logic st; logic [3:0] ch;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", "conv_start", int'(conv_start), 0);
    check("R1", "irq", int'(irq), 0);
    rd(7'h00, v); check("R1", "ctrl", v, 0);
    rd(7'h03, v); check("R1", "hi flags", v, 0);
    rd(7'h04, v); check("R1", "lo flags", v, 0);

    // configuration: list 5,2,9,5, limits per channel
    wr(7'h10, 16'd5); wr(7'h11, 16'd2); wr(7'h12, 16'd9); wr(7'h13, 16'd5);
    wr(7'h00, 16'h0030);
    wr(7'h25, 16'd1000); wr(7'h35, 16'd200);  wr(7'h45, 16'd50);
    wr(7'h22, 16'd500);  wr(7'h32, 16'd100);  wr(7'h42, 16'd0);
    wr(7'h29, 16'd3000); wr(7'h39, 16'd1000); wr(7'h49, 16'd100);

    // table walk: R4 order and wrap, R6/R7 set and rearm
    for (int i = 0; i < NV; i++) begin
      conv("R3", int'(VEC[i][51:48]), VEC[i][47:32]);
      rd(7'h03, v); check("R6", "hi flags", v, int'(VEC[i][31:16]));
      rd(7'h04, v); check("R7", "lo flags", v, int'(VEC[i][15:0]));
    end

    // R8 write-one-to-clear
    wr(7'h03, 16'h0004);
    rd(7'h03, v); check("R8", "partial clear", v, 16'h0020);
    wr(7'h03, 16'hFFFF); wr(7'h04, 16'hFFFF);
    rd(7'h03, v); check("R8", "hi cleared", v, 0);
    rd(7'h04, v); check("R8", "lo cleared", v, 0);

    // R6 hysteresis: a result inside the band must not rearm
    conv("R6", 5, 16'd1001);
    conv("R6", 2, 16'd700);
    conv("R7", 9, 16'd900);
    conv("R6", 5, 16'd980);
    wr(7'h03, 16'h0020);
    conv("R6", 5, 16'd1200);
    rd(7'h03, v); check("R6", "no retrigger inside band", v, 16'h0004);
    conv("R6", 2, 16'd200);
    conv("R7", 9, 16'd2000);

    // R9 interrupt masking
    check("R9", "irq masked", int'(irq), 0);
    wr(7'h01, 16'h0020); check("R9", "mask on clear flag", int'(irq), 0);
    wr(7'h01, 16'h0004); check("R9", "mask on set flag", int'(irq), 1);
    wr(7'h01, 16'h0000); wr(7'h02, 16'h0200); check("R9", "low mask", int'(irq), 1);
    wr(7'h04, 16'h0200); check("R9", "after clear", int'(irq), 0);

    // R10 stray result while idle (would trip armed ch9 low limit)
    give(16'd0);
    rd(7'h04, v); check("R10", "lo flags", v, 0);
    check("R10", "irq", int'(irq), 0);

    // R5 request while busy is dropped, pointer held
    pulse_ext(st, ch); check("R5", "first strobe", int'(st), 1);
    check("R4", "entry 3 channel", int'(ch), 5);
    pulse_ext(st, ch); check("R5", "dropped strobe", int'(st), 0);
    give(16'd600);
    conv("R5", 5, 16'd600);

    // R3 ticks ignored with auto off
    n = 0;
    for (int i = 0; i < 20; i++) begin pulse_tick(st); if (st) n++; end
    check("R3", "strobes from ticks", n, 0);

    // R2 auto mode, code 0
    wr(7'h00, 16'h0031);
    ticks_to_start(n); check("R2", "code0 ticks", n, 10);
    check("R4", "auto channel", int'(conv_ch), 2);
    give(16'd300);
    pulse_ext(st, ch); check("R3", "ext ignored in auto", int'(st), 0);

    // R2 auto mode, code 7, two periods in a row
    wr(7'h00, 16'h0030);
    wr(7'h00, 16'h003F);
    ticks_to_start(n); check("R2", "code7 first", n, 800);
    give(16'd2000);
    ticks_to_start(n); check("R2", "code7 repeat", n, 800);
    give(16'd600);
    wr(7'h00, 16'h0030);

    finish_run();
  end
endmodule